// File: doc/BRIEF.md
# Register-Triggered Multiply-Accumulate Unit

This block is a bus-attached hardware multiplier. Software programs a byte-wide mode register, then writes the two 16-bit operand registers. The operand writes themselves start the operation, so no separate start command exists. Depending on the mode, the operation starts when both operands have been written, when either operand is written, or when a single value is written and used as both operands for a square. The result goes to a 40-bit accumulator. The accumulator is read and written as three words.

The mode register selects the following: signed or unsigned operands, plain multiply or accumulate, add or subtract (for a plain signed multiply, this bit negates the product instead), and whether the result is written back at all. The top bit is a read-only overflow flag. A self-clearing clear bit zeroes the operands, the accumulator, the flag and the operand-load tracking in one write. Each operation runs one clock after the write that triggers it, and its result can be read on the cycle after that.

Top module: `mac_unit`

## Requirements
- R1: After reset, all six registers read 0: the mode register at address 0, operand A at 1, operand B at 2, and accumulator words at 3 (bits 15:0), 4 (bits 31:16) and 5 (bits 39:32, zero-extended).
- R2: The mode register bits are: 7 overflow flag (read-only), 6 writeback off, 5 clear, 4 square, 3 single-operand trigger, 2 negate/subtract, 1 accumulate, 0 unsigned. The operand and accumulator words read back what was last written to them.
- R3: With bits 4 and 3 at 0, an operation fires only once both A and B have been written since the last operation or clear, in either order. Rewriting the same operand does not fire it.
- R4: With bit 3 at 1 and bit 4 at 0, every write to A or B fires an operation using the current value of the other operand.
- R5: With bit 4 at 1, a write to either operand loads the value into both A and B and fires a square, whatever bit 3 holds.
- R6: With bit 1 at 0 and bit 2 at 0, the accumulator receives the product. The product is the sign-extended signed product when bit 0 is 0 and the zero-extended unsigned product when bit 0 is 1. It is readable on the cycle after the clock that follows the triggering write.
- R7: With bit 1 at 0, bit 2 at 1 and bit 0 at 0, the accumulator receives the negated signed product.
- R8: With bit 1 at 0, bit 2 at 1 and bit 0 at 1, the accumulator receives the 40-bit two's-complement negation of the unsigned product, and the overflow flag is set.
- R9: With bit 1 at 1, the product is added to the accumulator when bit 2 is 0 and subtracted from it when bit 2 is 1.
- R10: For accumulate and subtract, the overflow flag shows a signed 40-bit out-of-range result (bit 0 at 0) or a carry/borrow out of bit 39 (bit 0 at 1). Every new operation rewrites the flag, so a plain multiply clears it.
- R11: With bit 6 at 1, the accumulator keeps its contents while the overflow flag is still updated from the computed result.
- R12: Writing 1 to bit 5 zeroes both operands, the accumulator, the flag and the operand-load tracking. Bit 5 always reads 0, and writing the mode register with bit 5 at 0 leaves the data registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address for both read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data of the addressed register |

## Verification
On every cycle, the in-line assertions check the trigger rules and the operation that follows them. A square or single-operand write must start an operation on the next cycle. A clear must leave the operands, accumulator and flag at zero. Writeback-off must freeze the accumulator, and a plain multiply must never leave the flag set. The arithmetic itself can only be shown by the bench's scenarios: signed and unsigned products, negation, the signed and unsigned overflow boundaries of the 40-bit sum, and the order-independent two-operand trigger.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W   = 16;
    localparam int ACC_W  = 40;
    localparam int ADDR_W = 3;

    // mode register bit positions (software visible)
    localparam int CB_UNS = 0;
    localparam int CB_ACC = 1;
    localparam int CB_NEG = 2;
    localparam int CB_ONE = 3;
    localparam int CB_SQR = 4;
    localparam int CB_CLR = 5;
    localparam int CB_WBO = 6;
    localparam int CB_OVF = 7;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_OPA  = 3'd1,
        RA_OPB  = 3'd2,
        RA_ACC0 = 3'd3
    } reg_addr_e;

    // stored mode bits
    typedef struct packed {
        logic wb_off;
        logic square;
        logic single;
        logic negate;
        logic accum;
        logic unsgn;
    } mode_t;

    // the part of the mode an executing operation needs
    typedef struct packed {
        logic wb_off;
        logic negate;
        logic accum;
        logic unsgn;
    } exec_t;

    function automatic exec_t to_exec(mode_t m);
        exec_t e;
        e.wb_off = m.wb_off;
        e.negate = m.negate;
        e.accum  = m.accum;
        e.unsgn  = m.unsgn;
        return e;
    endfunction

    // signed overflow of x + y = r, given sign bits
    function automatic logic add_ovf(logic sx, logic sy, logic sr);
        return (sx == sy) && (sr != sx);
    endfunction

    // signed overflow of x - y = r, given sign bits
    function automatic logic sub_ovf(logic sx, logic sy, logic sr);
        return (sx != sy) && (sr != sx);
    endfunction

endpackage

// File: rtl/mac_ctrl_reg.sv
module mac_ctrl_reg
    import mac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  mode_t new_mode,
    output mode_t mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr_ctrl) begin
            mode <= new_mode;
        end
    end

endmodule

// File: rtl/mac_trigger.sv
module mac_trigger
    import mac_pkg::*;
#(
    parameter int OP_W = mac_pkg::OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            wr_a,
    input  logic            wr_b,
    input  logic [OP_W-1:0] wr_data,
    input  mode_t           mode,
    output logic [OP_W-1:0] op_a,
    output logic [OP_W-1:0] op_b,
    output logic            go,
    output exec_t           go_exec
);

    logic seen_a;
    logic seen_b;
    logic fire;

    always_comb begin
        if (mode.square || mode.single) begin
            fire = wr_a || wr_b;
        end else begin
            fire = (wr_a && seen_b) || (wr_b && seen_a);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            op_a    <= '0;
            op_b    <= '0;
            seen_a  <= 1'b0;
            seen_b  <= 1'b0;
            go      <= 1'b0;
            go_exec <= '0;
        end else begin
            go <= fire;
            if (fire) begin
                go_exec <= to_exec(mode);
            end
            if (mode.square && (wr_a || wr_b)) begin
                op_a <= wr_data;
                op_b <= wr_data;
            end else begin
                if (wr_a) op_a <= wr_data;
                if (wr_b) op_b <= wr_data;
            end
            if (fire) begin
                seen_a <= 1'b0;
                seen_b <= 1'b0;
            end else begin
                seen_a <= seen_a || wr_a;
                seen_b <= seen_b || wr_b;
            end
        end
    end

    // R5: a square write fills both operands and starts an operation
    p_square_load_r5: assert property (@(posedge clk) disable iff (rst)
        ((wr_a || wr_b) && mode.square && !clr) |=> (go && (op_a == op_b)));

    // R4: every operand write starts an operation in single-operand mode
    p_single_fire_r4: assert property (@(posedge clk) disable iff (rst)
        ((wr_a || wr_b) && mode.single && !clr) |=> go);

    // R3: with no operand write there is nothing to start
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_a && !wr_b) |=> !go);

    // R12: clear empties the operands and cancels any pending start
    p_clear_ops_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!go && (op_a == '0) && (op_b == '0)));

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int OP_W  = mac_pkg::OP_W,
    parameter int ACC_W = mac_pkg::ACC_W,
    parameter int NW    = (ACC_W + OP_W - 1) / OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             go,
    input  exec_t            go_exec,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [NW-1:0]    acc_wr,
    input  logic [OP_W-1:0]  wr_data,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);

    localparam int PW = 2 * OP_W;
    localparam int SW = ACC_W + 1;

    logic signed [PW-1:0] prod_s;
    logic [PW-1:0]        prod_u;
    logic [ACC_W-1:0]     prod;
    logic [SW-1:0]        sum;
    logic [SW-1:0]        dif;
    logic [ACC_W-1:0]     res;
    logic                 res_ovf;
    logic [ACC_W-1:0]     acc_bus;

    always_comb begin
        prod_s = PW'($signed(op_a)) * PW'($signed(op_b));
        prod_u = PW'(op_a) * PW'(op_b);
        if (go_exec.unsgn) begin
            prod = ACC_W'(prod_u);
        end else begin
            prod = ACC_W'(prod_s);
        end
        sum = {1'b0, acc} + {1'b0, prod};
        dif = {1'b0, acc} - {1'b0, prod};

        res     = prod;
        res_ovf = 1'b0;
        if (go_exec.accum) begin
            if (go_exec.negate) begin
                res     = dif[ACC_W-1:0];
                res_ovf = go_exec.unsgn ? dif[ACC_W]
                        : sub_ovf(acc[ACC_W-1], prod[ACC_W-1], dif[ACC_W-1]);
            end else begin
                res     = sum[ACC_W-1:0];
                res_ovf = go_exec.unsgn ? sum[ACC_W]
                        : add_ovf(acc[ACC_W-1], prod[ACC_W-1], sum[ACC_W-1]);
            end
        end else if (go_exec.negate) begin
            res     = {ACC_W{1'b0}} - prod;
            res_ovf = go_exec.unsgn;
        end
    end

    // bus writes to individual accumulator words
    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam int LO = i * OP_W;
        localparam int WW = (ACC_W - LO < OP_W) ? (ACC_W - LO) : OP_W;
        assign acc_bus[LO +: WW] = acc_wr[i] ? wr_data[WW-1:0] : acc[LO +: WW];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (go) begin
            ovf <= res_ovf;
            if (!go_exec.wb_off) begin
                acc <= res;
            end
        end else begin
            acc <= acc_bus;
        end
    end

    // R11: suppressed writeback leaves the accumulator as it was
    p_wb_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (go && go_exec.wb_off && !clr) |=> (acc == $past(acc)));

    // R10: a plain multiply (not unsigned-negate) never leaves overflow set
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (go && !clr && !go_exec.accum && !(go_exec.negate && go_exec.unsgn)) |=> !ovf);

    // R8: unsigned negate always flags overflow
    p_uneg_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (go && !clr && !go_exec.accum && go_exec.negate && go_exec.unsgn) |=> ovf);

    // R12: clear zeroes accumulator and flag
    p_clear_acc_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((acc == '0) && !ovf));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W   = mac_pkg::OP_W,
    parameter int ACC_W  = mac_pkg::ACC_W,
    parameter int ADDR_W = mac_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_data,
    output logic [OP_W-1:0]   rd_data
);

    localparam int NW = (ACC_W + OP_W - 1) / OP_W;

    logic             wr_ctrl;
    logic             wr_a;
    logic             wr_b;
    logic             clr;
    logic [NW-1:0]    acc_wr;
    mode_t            new_mode;
    mode_t            mode;
    logic [OP_W-1:0]  op_a;
    logic [OP_W-1:0]  op_b;
    logic             go;
    exec_t            go_exec;
    logic [ACC_W-1:0] acc;
    logic             ovf;
    logic [OP_W-1:0]  acc_word [NW];

    assign wr_ctrl = wr_en && (addr == ADDR_W'(RA_CTRL));
    assign wr_a    = wr_en && (addr == ADDR_W'(RA_OPA));
    assign wr_b    = wr_en && (addr == ADDR_W'(RA_OPB));
    assign clr     = wr_ctrl && wr_data[CB_CLR];

    always_comb begin
        new_mode.wb_off = wr_data[CB_WBO];
        new_mode.square = wr_data[CB_SQR];
        new_mode.single = wr_data[CB_ONE];
        new_mode.negate = wr_data[CB_NEG];
        new_mode.accum  = wr_data[CB_ACC];
        new_mode.unsgn  = wr_data[CB_UNS];
    end

    for (genvar i = 0; i < NW; i++) begin : g_acc_map
        localparam int LO = i * OP_W;
        localparam int WW = (ACC_W - LO < OP_W) ? (ACC_W - LO) : OP_W;
        assign acc_wr[i]   = wr_en && (addr == ADDR_W'(int'(RA_ACC0) + i));
        assign acc_word[i] = OP_W'(acc[LO +: WW]);
    end

    mac_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .new_mode (new_mode),
        .mode     (mode)
    );

    mac_trigger #(.OP_W(OP_W)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_data (wr_data),
        .mode    (mode),
        .op_a    (op_a),
        .op_b    (op_b),
        .go      (go),
        .go_exec (go_exec)
    );

    mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W), .NW(NW)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .go      (go),
        .go_exec (go_exec),
        .op_a    (op_a),
        .op_b    (op_b),
        .acc_wr  (acc_wr),
        .wr_data (wr_data),
        .acc     (acc),
        .ovf     (ovf)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(RA_CTRL)) begin
            rd_data = OP_W'({ovf, mode.wb_off, 1'b0, mode.square,
                             mode.single, mode.negate, mode.accum, mode.unsgn});
        end else if (addr == ADDR_W'(RA_OPA)) begin
            rd_data = op_a;
        end else if (addr == ADDR_W'(RA_OPB)) begin
            rd_data = op_b;
        end
        for (int i = 0; i < NW; i++) begin
            if (addr == ADDR_W'(int'(RA_ACC0) + i)) rd_data = acc_word[i];
        end
    end

    // R2: the clear bit never reads back as 1
    p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(RA_CTRL)) |-> !rd_data[CB_CLR]);

endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mac_unit dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    typedef struct packed {
        logic [7:0]  mode;
        logic [15:0] a;
        logic [15:0] b;
        logic [39:0] init;
        logic [39:0] exp;
        logic        eovf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h0003, 16'hFFFB, 40'h0,          40'hFFFFFFFFF1, 1'b0}, // R6 signed
        '{8'h01, 16'hFFFF, 16'hFFFF, 40'h0,          40'h00FFFE0001, 1'b0}, // R6 unsigned
        '{8'h04, 16'h0007, 16'h0006, 40'h0,          40'hFFFFFFFFD6, 1'b0}, // R7
        '{8'h05, 16'h0002, 16'h0003, 40'h0,          40'hFFFFFFFFFA, 1'b1}, // R8
        '{8'h02, 16'hFFFE, 16'h000A, 40'h64,         40'h0000000050, 1'b0}, // R9 add
        '{8'h06, 16'h0004, 16'h0004, 40'h5,          40'hFFFFFFFFF5, 1'b0}, // R9 sub
        '{8'h02, 16'h0001, 16'h0001, 40'h7FFFFFFFFF, 40'h8000000000, 1'b1}, // R10 signed add
        '{8'h06, 16'h0001, 16'h0001, 40'h8000000000, 40'h7FFFFFFFFF, 1'b1}, // R10 signed sub
        '{8'h03, 16'h0001, 16'h0001, 40'hFFFFFFFFFF, 40'h0000000000, 1'b1}, // R10 carry
        '{8'h07, 16'h0001, 16'h0002, 40'h0,          40'hFFFFFFFFFE, 1'b1}, // R10 borrow
        '{8'h10, 16'hFFFD, 16'h0000, 40'h0,          40'h0000000009, 1'b0}, // R5 square
        '{8'h13, 16'h0100, 16'h0000, 40'hA,          40'h000001000A, 1'b0}, // R5 square-acc
        '{8'h40, 16'h0005, 16'h0005, 40'h123456789A, 40'h123456789A, 1'b0}, // R11
        '{8'h45, 16'h0001, 16'h0001, 40'h77,         40'h0000000077, 1'b1}  // R11 flag
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic get_acc(output logic [39:0] v);
        logic [15:0] w0, w1, w2;
        rd(3'd3, w0);
        rd(3'd4, w1);
        rd(3'd5, w2);
        v = {w2[7:0], w1, w0};
    endtask

    task automatic set_acc(input logic [39:0] v);
        wr(3'd3, v[15:0]);
        wr(3'd4, v[31:16]);
        wr(3'd5, {8'h00, v[39:32]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [39:0] av;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            check("R1 reset read", 64'(d), 64'h0);
        end

        // R2: readback of operands, accumulator words, mode bits
        wr(3'd0, 16'h0020);
        wr(3'd1, 16'h1234);
        rd(3'd1, d);
        check("R2 opA readback", 64'(d), 64'h1234);
        wr(3'd3, 16'hBEEF);
        wr(3'd4, 16'hCAFE);
        wr(3'd5, 16'h12AB);
        rd(3'd5, d);
        check("R2 acc top word zero-extended", 64'(d), 64'h00AB);
        get_acc(av);
        check("R2 acc readback", 64'(av), 64'hABCAFEBEEF);
        wr(3'd0, 16'h005F);
        rd(3'd0, d);
        check("R2 mode readback, clear bit 0", 64'(d), 64'h005F);

        // R12: mode write with bit 5 low leaves data alone
        get_acc(av);
        check("R12 write-0 keeps acc", 64'(av), 64'hABCAFEBEEF);
        rd(3'd1, d);
        check("R12 write-0 keeps opA", 64'(d), 64'h1234);

        // R3: two-operand trigger, A twice then B
        wr(3'd0, 16'h0020);
        wr(3'd1, 16'h0002);
        wr(3'd1, 16'h0003);
        settle();
        get_acc(av);
        check("R3 repeat A no fire", 64'(av), 64'h0);
        wr(3'd2, 16'h0004);
        settle();
        get_acc(av);
        check("R3 A then B fires", 64'(av), 64'hC);
        // R3: B then A
        wr(3'd0, 16'h0020);
        wr(3'd2, 16'h0005);
        settle();
        get_acc(av);
        check("R3 B alone no fire", 64'(av), 64'h0);
        wr(3'd1, 16'h0006);
        settle();
        get_acc(av);
        check("R3 B then A fires", 64'(av), 64'h1E);

        // R12: clear resets the load tracking
        wr(3'd0, 16'h0020);
        wr(3'd1, 16'h0009);
        wr(3'd0, 16'h0020);
        rd(3'd1, d);
        check("R12 clear zeroes opA", 64'(d), 64'h0);
        wr(3'd2, 16'h0002);
        settle();
        get_acc(av);
        check("R12 tracking reset, no fire", 64'(av), 64'h0);
        wr(3'd1, 16'h0003);
        settle();
        get_acc(av);
        check("R12 fires after both", 64'(av), 64'h6);

        // R4: single-operand trigger with accumulate
        wr(3'd0, 16'h002A);
        wr(3'd2, 16'h0003);
        settle();
        get_acc(av);
        check("R4 B fires with A=0", 64'(av), 64'h0);
        wr(3'd1, 16'h0007);
        settle();
        get_acc(av);
        check("R4 A fires", 64'(av), 64'd21);
        wr(3'd1, 16'h0002);
        settle();
        get_acc(av);
        check("R4 A again fires", 64'(av), 64'd27);

        // R5: square overrides single-operand select, via B
        wr(3'd0, 16'h0038);
        wr(3'd2, 16'hFFFC);
        rd(3'd1, d);
        check("R5 square loads A", 64'(d), 64'hFFFC);
        settle();
        get_acc(av);
        check("R5 square result", 64'(av), 64'd16);

        // R10: new plain multiply clears overflow
        wr(3'd0, 16'h0022);
        set_acc(40'h7FFFFFFFFF);
        wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0001);
        settle();
        rd(3'd0, d);
        check("R10 overflow set", 64'(d[7]), 64'h1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0001);
        settle();
        rd(3'd0, d);
        check("R10 overflow cleared by new op", 64'(d[7]), 64'h0);
        get_acc(av);
        check("R10 plain result", 64'(av), 64'h1);

        // table of modes: R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, {8'h00, VECS[v].mode | 8'h20});
            set_acc(VECS[v].init);
            wr(3'd1, VECS[v].a);
            if (!VECS[v].mode[4]) wr(3'd2, VECS[v].b);
            settle();
            get_acc(av);
            check($sformatf("R6-table vec%0d acc", v), 64'(av), 64'(VECS[v].exp));
            rd(3'd0, d);
            check($sformatf("R10-table vec%0d mode/flag", v), 64'(d),
                  64'({VECS[v].eovf, VECS[v].mode[6:0]}));
        end

        // R12: clear zeroes flag and accumulator together
        wr(3'd0, 16'h0020);
        rd(3'd0, d);
        check("R12 clear flag", 64'(d), 64'h0);
        get_acc(av);
        check("R12 clear acc", 64'(av), 64'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule